// File: doc/BRIEF.md
# Serial DAC Input Control Register

This block is the digital front end of a 12-bit voltage-output converter. A host writes it over a three-wire serial link made of an active-low frame-select line, a serial clock and a data line. The block samples all three pins in its own system clock domain and passes them through two-flop synchronizers. It shifts data in on each falling serial clock edge. When a complete 16-bit frame has arrived, it loads a 12-bit output code and a 2-bit power mode. The mode selects normal drive, a 1 kΩ pull to ground, a 100 kΩ pull to ground or a floating output.

A frame is committed only when its sixteenth falling clock edge is seen while frame-select is still low. If frame-select returns high before that edge, the frame is dropped without any effect. Each commit raises a single-cycle update pulse. This pulse is a plain notification and has no ready or back-pressure: the code and mode outputs simply hold their values until the next valid frame. The system clock must run at least four times faster than the serial clock.

Top module: `sdac_front`

## Requirements
- R1: After reset the code output is 0, the mode output is 00 (normal) and the update strobe is low.
- R2: Data is shifted in on falling serial clock edges only, with the most significant bit first. Of a 16-bit frame, the first two bits received are ignored. The third and fourth bits form the mode (third bit is mode[1]). The last twelve bits form the code, MSB first.
- R3: The code and mode outputs change only in response to the sixteenth falling serial clock edge of a frame. After fifteen edges, nothing has changed yet.
- R4: If frame-select goes high before the sixteenth falling edge, the frame is discarded: code, mode and strobe are unaffected, and the next full frame decodes correctly.
- R5: Falling serial clock edges after the sixteenth, while frame-select stays low, are ignored and give no second update.
- R6: A new frame starts only when frame-select goes high and then low again. Clocking with frame-select held low after a commit has no effect.
- R7: Mode encoding: 00 normal, 01 output to ground through 1 kΩ, 10 output to ground through 100 kΩ, 11 high impedance. A frame whose mode is not 00 updates the mode and leaves the code output unchanged. A frame with mode 00 loads both.
- R8: Serial clock edges while frame-select is high shift nothing and count nothing.
- R9: The update strobe is high for exactly one system clock cycle per committed frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock pin (asynchronous) |
| sync_n_i | input | 1 | Frame-select pin, active low (asynchronous) |
| din_i | input | 1 | Serial data pin (asynchronous) |
| code_o | output | 12 | Committed converter code |
| pmode_o | output | 2 | Committed power mode |
| upd_o | output | 1 | One-cycle pulse when a frame commits |

## Verification
The bench aborts a frame after every possible count of edges from zero to fifteen. A design that commits early, or that keeps stale shift contents, would show a changed code or an extra strobe. It then clocks past the sixteenth edge and also clocks with frame-select held low after a commit. A counter that wraps around instead of stopping would commit a second, corrupted word. It sweeps every mode and padding combination, so a design that slices the fields one place off, or that overwrites the code during a power-down write, gives wrong outputs. It also toggles the clock with frame-select high, which catches any front end that counts edges outside a frame.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int PAD_W  = 2;
  localparam int MODE_W = 2;
  localparam int CODE_W = 12;

  typedef enum logic [1:0] {
    PM_ON       = 2'b00,
    PM_GND_1K   = 2'b01,
    PM_GND_100K = 2'b10,
    PM_HIZ      = 2'b11
  } pmode_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int FRAME_W   = 16,
  parameter int PAYLOAD_W = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_s,
  input  logic                 sync_s,   // high = idle / abort
  input  logic                 din_s,
  output logic                 commit_o,
  output logic [PAYLOAD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic                 sclk_d, sync_d;
  logic                 active;
  logic [CNT_W-1:0]     cnt;
  logic [PAYLOAD_W-2:0] shreg;
  logic                 fall_sclk, sync_fall, last_edge;

  assign fall_sclk = sclk_d & ~sclk_s;
  assign sync_fall = sync_d & ~sync_s;
  assign last_edge = active & fall_sclk & ~sync_s & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      sync_d <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      sync_d <= sync_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else if (sync_s) begin
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else if (sync_fall) begin
      active <= 1'b1;
      cnt    <= '0;
      shreg  <= '0;
    end else if (active && fall_sclk) begin
      shreg <= {shreg[PAYLOAD_W-3:0], din_s};
      cnt   <= cnt + 1'b1;
      if (last_edge) active <= 1'b0;
    end
  end

  assign commit_o = last_edge;
  assign word_o   = {shreg, din_s};

  // R6: a frame is armed only after frame-select was seen high
  assert_start_after_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(sync_d));

  // R8: clock edges outside a frame leave the bit counter alone
  assert_idle_edges_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_sclk && !active && !sync_fall) |=> $stable(cnt));
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int CODE_W_P = 12,
  parameter int MODE_W_P = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit_i,
  input  logic [MODE_W_P+CODE_W_P-1:0] word_i,
  output logic [CODE_W_P-1:0]          code_o,
  output logic [MODE_W_P-1:0]          mode_o,
  output logic                         upd_o
);
  logic [CODE_W_P-1:0] code_q;
  logic [MODE_W_P-1:0] mode_q;
  logic                upd_q;
  logic [MODE_W_P-1:0] mode_f;
  logic [CODE_W_P-1:0] code_f;
  logic                pd_req;

  assign mode_f = word_i[CODE_W_P +: MODE_W_P];
  assign code_f = word_i[CODE_W_P-1:0];
  assign pd_req = (mode_f != MODE_W_P'(PM_ON));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mode_q <= MODE_W_P'(PM_ON);
      upd_q  <= 1'b0;
    end else begin
      upd_q <= commit_i;
      if (commit_i) begin
        mode_q <= mode_f;
        if (!pd_req) code_q <= code_f;
      end
    end
  end

  assign code_o = code_q;
  assign mode_o = mode_q;
  assign upd_o  = upd_q;

  // R3: outputs move only on a commit from the shift stage
  assert_hold_without_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(code_q) && $stable(mode_q)));

  // R7: a power-down write leaves the code as it was
  assert_pd_keeps_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && mode_q != MODE_W_P'(PM_ON)) |-> $stable(code_q));

  // R9: the update strobe never lasts two cycles
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int CODE_W_P    = CODE_W,
  parameter int MODE_W_P    = MODE_W,
  parameter int PAD_W_P     = PAD_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_i,
  input  logic                sync_n_i,
  input  logic                din_i,
  output logic [CODE_W_P-1:0] code_o,
  output logic [MODE_W_P-1:0] pmode_o,
  output logic                upd_o
);
  localparam int PAYLOAD_W = MODE_W_P + CODE_W_P;
  localparam int FRAME_W   = PAD_W_P + PAYLOAD_W;

  logic [2:0]           pins_s;
  logic                 commit;
  logic [PAYLOAD_W-1:0] word;

  sdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk_i, sync_n_i, din_i}),
    .q     (pins_s)
  );

  sdac_shift #(.FRAME_W(FRAME_W), .PAYLOAD_W(PAYLOAD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (pins_s[2]),
    .sync_s   (pins_s[1]),
    .din_s    (pins_s[0]),
    .commit_o (commit),
    .word_o   (word)
  );

  sdac_regs #(.CODE_W_P(CODE_W_P), .MODE_W_P(MODE_W_P)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (commit),
    .word_i   (word),
    .code_o   (code_o),
    .mode_o   (pmode_o),
    .upd_o    (upd_o)
  );
endmodule

// File: tb/sdac_front_tb.sv
module sdac_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, sync_n = 1'b1, din = 1'b0;
  logic [11:0] code;
  logic [1:0]  pmode;
  logic        upd;

  int checks = 0, errors = 0, strobes = 0, wide = 0;
  logic [11:0] exp_code = '0;
  logic [1:0]  exp_mode = '0;
  int          exp_strb = 0;
  logic        upd_prev = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  sdac_front u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n), .din_i(din),
    .code_o(code), .pmode_o(pmode), .upd_o(upd)
  );

  always @(posedge clk) begin
    if (upd) strobes++;
    if (upd && upd_prev) wide++;
    upd_prev <= upd;
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, code, exp_code);
    chk(req, pmode, exp_mode);
    chk(req, strobes, exp_strb);
  endtask

  task automatic edge1(input logic b);
    din = b; sclk = 1'b1; wcyc(4);
    sclk = 1'b0; wcyc(4);
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input int extra, input bit rel);
    sync_n = 1'b1; wcyc(4);
    sync_n = 1'b0; wcyc(4);
    for (int i = 0; i < nbits; i++) edge1(w[15-i]);
    for (int i = 0; i < extra; i++) edge1(~w[i]);
    if (rel) sync_n = 1'b1;
    wcyc(12);
  endtask

  function automatic void model(input logic [15:0] w);
    exp_mode = w[13:12];
    if (w[13:12] == 2'b00) exp_code = w[11:0];
    exp_strb++;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    wcyc(3); rst_n = 1'b1; wcyc(3);
    // R1 reset state
    chk("R1 code", code, 0); chk("R1 mode", pmode, 0); chk("R1 strobe", upd, 0);

    // R2/R7: every mode and padding value
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 4; p++) begin
        w = {p[1:0], m[1:0], 12'((m * 997 + p * 311 + 5) & 12'hFFF)};
        frame(w, 16, 0, 1'b1); model(w); chk_state("R2/R7 field decode");
      end

    // R2: code sweep in normal mode
    for (int c = 0; c < 4096; c += 63) begin
      w = {2'b10, 2'b00, c[11:0]};
      frame(w, 16, 0, 1'b1); model(w); chk_state("R2 code sweep");
    end
    w = 16'h0FFF; frame(w, 16, 0, 1'b1); model(w); chk_state("R2 full scale");

    // R4: abort after every edge count below sixteen
    for (int n = 0; n < 16; n++) begin
      frame(16'hF5A3 ^ 16'(n), n, 0, 1'b1); chk_state("R4 aborted frame");
    end
    w = 16'h0123; frame(w, 16, 0, 1'b1); model(w); chk_state("R4 frame after aborts");

    // R3: nothing after fifteen edges, update on the sixteenth
    w = 16'h0ABC;
    frame(w, 15, 0, 1'b0); chk_state("R3 before 16th edge");
    edge1(w[0]); wcyc(8); model(w); chk_state("R3 on 16th edge");
    sync_n = 1'b1; wcyc(8);

    // R5: extra edges after the sixteenth
    w = 16'h0555; frame(w, 16, 6, 1'b1); model(w); chk_state("R5 extra edges");

    // R6: sync held low after commit, more clocking
    w = 16'h0777; frame(w, 16, 0, 1'b0); model(w); chk_state("R6 commit held low");
    for (int i = 0; i < 16; i++) edge1(1'b1);
    wcyc(8); chk_state("R6 no restart without sync high");
    w = 16'h0321; frame(w, 16, 0, 1'b1); model(w); chk_state("R6 next frame after rise");

    // R8: clocking with sync high
    sync_n = 1'b1;
    for (int i = 0; i < 20; i++) edge1(i[0]);
    wcyc(8); chk_state("R8 idle clocking");
    w = 16'h0246; frame(w, 16, 0, 1'b1); model(w); chk_state("R8 frame after idle clocking");

    // R7: power-down then back to normal
    w = 16'h3FFF; frame(w, 16, 0, 1'b1); model(w); chk_state("R7 hiz keeps code");
    w = 16'h0001; frame(w, 16, 0, 1'b1); model(w); chk_state("R7 back to normal");

    // R9
    chk("R9 strobe width", wide, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule